// File: doc/BRIEF.md
# Time-Wheel Event Scheduler

This block holds pending signal-change events for a hardware logic-simulation engine. Time is kept as a ring of slots, one per time unit, sized so that the longest permitted delay still lands in a slot other than the current one. A gate evaluator hands in an event made of a signal number, a new one-bit value and a delay. The block files it in the slot that lies that many time units ahead of the current-time pointer.

The block presents the events of the current slot one at a time on a valid/ready stream. When the current slot is empty and work is still pending elsewhere, the pointer steps to the next slot. When no slot holds anything, the block raises idle and the pointer stays where it is.

Before queuing, each event is compared with the value last queued for the same signal. An event that would repeat that value is dropped without any flag. A monitor counts the events emitted since the most recent primary-input change. It raises a sticky oscillation flag once that count passes a limit supplied on an input.

Top module: `tw_event_sched`

## Requirements
- R1: After reset, `idle` is 1, `ev_valid` is 0, `now_slot` is 0, and `sch_err`, `sch_ovf` and `osc_flag` are 0.
- R2: An accepted event with delay d, scheduled while `now_slot` is c, is emitted with its own id and value while `now_slot` equals (c + d) mod (MAX_DLY + 1).
- R3: Events in one slot come out in the order they were scheduled, one per cycle in which `ev_valid` and `ev_ready` are both 1. While `ev_ready` is 0, the head event and `now_slot` hold.
- R4: When the current slot is empty and another slot is not, `now_slot` steps by one per clock and wraps from MAX_DLY to 0. Starting from idle, an event with delay d appears d cycles after the edge that captured it.
- R5: When every slot is empty, `idle` is 1 and `now_slot` does not change.
- R6: A schedule request with delay 0 or delay above MAX_DLY raises `sch_err` for exactly the cycle after the capturing edge. It queues nothing and changes no last-scheduled value. A delay equal to MAX_DLY is accepted.
- R7: Each signal keeps its last-scheduled value in three states (0, 1, unknown), and reset sets all of them to unknown. A request whose value equals that signal's last-scheduled value is dropped without any flag. Any other request that is accepted updates the stored value.
- R8: Each slot holds SLOT_DEPTH events. A request aimed at a full slot raises `sch_ovf` for the cycle after the capturing edge and is dropped, and the signal's last-scheduled value is left unchanged.
- R9: Every emitted event adds one to a saturating counter. `osc_flag` becomes 1 once the counter exceeds `osc_limit` and stays 1 until reset. A count equal to the limit does not set it.
- R10: A cycle with `pi_change` at 1 clears the counter, so only events emitted after the most recent pulse are compared with the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sch_valid | input | 1 | Schedule request strobe |
| sch_id | input | SIG_W | Signal number of the request |
| sch_val | input | 1 | New value of the signal |
| sch_dly | input | DLY_W | Delay in time units |
| ev_valid | output | 1 | Head event of current slot is present |
| ev_ready | input | 1 | Consumer takes the head event |
| ev_id | output | SIG_W | Signal number of head event |
| ev_val | output | 1 | Value of head event |
| now_slot | output | SLOT_W | Current-time pointer |
| idle | output | 1 | No event pending in any slot |
| pi_change | input | 1 | Primary-input change pulse; clears the event counter |
| osc_limit | input | CNT_W | Event count above which oscillation is assumed |
| sch_err | output | 1 | Pulse: request with illegal delay |
| sch_ovf | output | 1 | Pulse: request dropped on a full slot |
| osc_flag | output | 1 | Sticky suspected-oscillation flag |

## Verification
Single events with a short delay and with the full delay show where the slot index lands, including the wrap of the ring. They also show how many cycles pass while the pointer sweeps toward the event. A burst of events to one slot, with the consumer held off, separates FIFO order and stall behaviour from plain pointer motion, and its ninth entry exposes the overflow drop and the rule that a dropped event leaves the last-scheduled value alone. Repeated and alternating values on one signal separate redundant-event suppression from the illegal-delay path. Event bursts of exactly the limit and one past it, split by primary-input pulses, show the strict comparison and the counter clear.

// File: rtl/tw_pkg.sv
// Shared types for the time-wheel event scheduler.
package tw_pkg;
    // Three-state record of the last value queued for a signal.
    typedef enum logic [1:0] {
        LV_ZERO = 2'b00,
        LV_ONE  = 2'b01,
        LV_UNK  = 2'b10
    } lv_t;
endpackage

// File: rtl/tw_slot_fifo.sv
// One slot of the time wheel: a small FIFO of {id, value} words.
// Assumes the caller never pushes when full nor pops when empty;
// both are checked below. DEPTH need not be a power of two.
module tw_slot_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_p, wr_p;
    logic [CW-1:0] cnt;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign dout  = mem[rd_p];

    // Store an incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_p] <= din;
    end

    // Advance pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (push && !full)
                wr_p <= (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
            if (pop && !empty)
                rd_p <= (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
            case ({push && !full, pop && !empty})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/tw_lsv_table.sv
// Last-scheduled-value table: one three-state entry per signal.
// Reset marks every entry unknown; reads are combinational.
module tw_lsv_table
    import tw_pkg::*;
#(
    parameter int SIG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIG_W-1:0] rd_id,
    output lv_t              rd_val,
    input  logic             wr_en,
    input  logic [SIG_W-1:0] wr_id,
    input  logic             wr_bit
);
    localparam int NSIG = 1 << SIG_W;

    lv_t tbl [NSIG];

    assign rd_val = tbl[rd_id];

    // Reset all entries to unknown, else record an accepted value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSIG; i++) tbl[i] <= LV_UNK;
        end else if (wr_en) begin
            tbl[wr_id] <= wr_bit ? LV_ONE : LV_ZERO;
        end
    end

    // R7
    written_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl[$past(wr_id)] != LV_UNK));
endmodule

// File: rtl/tw_osc_mon.sv
// Oscillation monitor: counts emitted events since the last
// primary-input pulse and sets a sticky flag past the limit.
// The counter saturates at its all-ones value.
module tw_osc_mon #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hit,
    input  logic [CNT_W-1:0] limit,
    output logic             flag
);
    logic [CNT_W-1:0] cnt, cnt_nx;

    // Next count: clear has priority, then saturating increment.
    always_comb begin
        if (clear)                   cnt_nx = '0;
        else if (hit && (cnt != '1)) cnt_nx = cnt + 1'b1;
        else                         cnt_nx = cnt;
    end

    // Register count and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            cnt  <= cnt_nx;
            flag <= flag | (cnt_nx > limit);
        end
    end

    // R9
    osc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit));
    // R9
    osc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);
    // R10
    osc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
endmodule

// File: rtl/tw_event_sched.sv
// Time-wheel event scheduler. MAX_DLY+1 slots form a ring; an event
// with delay d goes to slot (now + d) mod (MAX_DLY+1). The head of
// the current slot is offered on a valid/ready stream; the pointer
// steps when the current slot is empty and work remains elsewhere.
// Assumes DLY_W can represent MAX_DLY.
module tw_event_sched
    import tw_pkg::*;
#(
    parameter int SIG_W      = 4,
    parameter int MAX_DLY    = 7,
    parameter int DLY_W      = 4,
    parameter int SLOT_DEPTH = 8,
    parameter int CNT_W      = 8,
    localparam int NSLOT     = MAX_DLY + 1,
    localparam int SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sch_valid,
    input  logic [SIG_W-1:0]  sch_id,
    input  logic              sch_val,
    input  logic [DLY_W-1:0]  sch_dly,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [SIG_W-1:0]  ev_id,
    output logic              ev_val,
    output logic [SLOT_W-1:0] now_slot,
    output logic              idle,
    input  logic              pi_change,
    input  logic [CNT_W-1:0]  osc_limit,
    output logic              sch_err,
    output logic              sch_ovf,
    output logic              osc_flag
);
    localparam int EW    = SIG_W + 1;
    localparam int SUM_W = ((DLY_W > SLOT_W) ? DLY_W : SLOT_W) + 1;

    logic [SLOT_W-1:0] cur;
    logic [EW-1:0]     s_dout [NSLOT];
    logic [NSLOT-1:0]  s_full, s_empty, push_v, pop_v;
    logic [SUM_W-1:0]  sum_raw, sum_mod;
    logic [SLOT_W-1:0] tgt;
    logic              dly_bad, same_val, tgt_full, accept, fire;
    lv_t               last_v;
    logic [EW-1:0]     head;

    assign now_slot = cur;
    assign idle     = &s_empty;
    assign ev_valid = !s_empty[cur];
    assign head     = s_dout[cur];
    assign ev_id    = head[EW-1:1];
    assign ev_val   = head[0];
    assign fire     = ev_valid && ev_ready;

    // Target slot: current pointer plus delay, folded into the ring.
    always_comb begin
        sum_raw = SUM_W'(cur) + SUM_W'(sch_dly);
        sum_mod = (sum_raw >= SUM_W'(NSLOT)) ? sum_raw - SUM_W'(NSLOT) : sum_raw;
        tgt     = SLOT_W'(sum_mod);
    end

    // Classify the request: delay legality, redundancy, capacity.
    always_comb begin
        dly_bad  = (sch_dly == '0) || (sch_dly > DLY_W'(MAX_DLY));
        same_val = (last_v == (sch_val ? LV_ONE : LV_ZERO));
        tgt_full = s_full[tgt];
        accept   = sch_valid && !dly_bad && !same_val && !tgt_full;
    end

    // Per-slot push and pop strobes.
    always_comb begin
        for (int k = 0; k < NSLOT; k++) begin
            push_v[k] = accept && (tgt == SLOT_W'(k));
            pop_v[k]  = fire && (cur == SLOT_W'(k));
        end
    end

    // Slot FIFOs, one per time unit of the ring.
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        tw_slot_fifo #(
            .DEPTH (SLOT_DEPTH),
            .W     (EW)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[k]),
            .pop   (pop_v[k]),
            .din   ({sch_id, sch_val}),
            .dout  (s_dout[k]),
            .full  (s_full[k]),
            .empty (s_empty[k])
        );
    end

    // Last-scheduled values per signal.
    tw_lsv_table #(
        .SIG_W (SIG_W)
    ) u_lsv (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_id  (sch_id),
        .rd_val (last_v),
        .wr_en  (accept),
        .wr_id  (sch_id),
        .wr_bit (sch_val)
    );

    // Event counter and oscillation flag.
    tw_osc_mon #(
        .CNT_W (CNT_W)
    ) u_osc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pi_change),
        .hit   (fire),
        .limit (osc_limit),
        .flag  (osc_flag)
    );

    // Step the time pointer when the current slot is drained.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cur <= '0;
        else if (s_empty[cur] && !idle)
            cur <= (cur == SLOT_W'(NSLOT - 1)) ? '0 : cur + 1'b1;
    end

    // One-cycle error and overflow pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sch_err <= 1'b0;
            sch_ovf <= 1'b0;
        end else begin
            sch_err <= sch_valid && dly_bad;
            sch_ovf <= sch_valid && !dly_bad && !same_val && tgt_full;
        end
    end

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> $stable(cur));
    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur) |-> (cur == (($past(cur) == SLOT_W'(NSLOT - 1)) ? '0 : $past(cur) + 1'b1)));
    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> ($stable(cur) && ev_valid && $stable(ev_id)));
    // R6
    zero_dly_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_valid && (sch_dly == '0)) |=> sch_err);
    // R2
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> !idle);
endmodule

// File: tb/tw_event_sched_tb.sv
// Directed bench for the time-wheel event scheduler.
module tw_event_sched_tb_top;
    localparam int SIG_W = 4, MAX_DLY = 7, DLY_W = 4, DEPTH = 8, CNT_W = 8;
    localparam int NS = MAX_DLY + 1;
    localparam int SW = $clog2(NS);

    logic clk = 1'b0;
    logic rst_n;
    logic sch_valid, sch_val, ev_ready, pi_change;
    logic [SIG_W-1:0] sch_id;
    logic [DLY_W-1:0] sch_dly;
    logic [CNT_W-1:0] osc_limit;
    logic ev_valid, ev_val, idle, sch_err, sch_ovf, osc_flag;
    logic [SIG_W-1:0] ev_id;
    logic [SW-1:0] now_slot;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int g_id [32], g_val [32], g_slot [32];
    int g_n, g_first;

    always #2.5 clk = ~clk;

    tw_event_sched #(
        .SIG_W (SIG_W), .MAX_DLY (MAX_DLY), .DLY_W (DLY_W),
        .SLOT_DEPTH (DEPTH), .CNT_W (CNT_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .sch_valid (sch_valid), .sch_id (sch_id),
        .sch_val (sch_val), .sch_dly (sch_dly), .ev_valid (ev_valid),
        .ev_ready (ev_ready), .ev_id (ev_id), .ev_val (ev_val),
        .now_slot (now_slot), .idle (idle), .pi_change (pi_change),
        .osc_limit (osc_limit), .sch_err (sch_err), .sch_ovf (sch_ovf),
        .osc_flag (osc_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0; sch_valid = 0; sch_id = '0; sch_val = 0; sch_dly = '0;
        ev_ready = 0; pi_change = 0; osc_limit = '1;
        repeat (3) tick();
        rst_n = 1;
        tick();
    endtask

    task automatic sched(input int id, input int val, input int dly);
        sch_id = SIG_W'(id); sch_val = val[0]; sch_dly = DLY_W'(dly);
        sch_valid = 1;
        tick();
        sch_valid = 0;
    endtask

    task automatic pi_pulse();
        pi_change = 1;
        tick();
        pi_change = 0;
    endtask

    // Take every pending event, recording id, value and slot.
    task automatic drain();
        ev_ready = 1; g_n = 0; g_first = -1;
        for (int c = 0; c < 64; c++) begin
            if (ev_valid) begin
                if (g_first < 0) g_first = c;
                if (g_n < 32) begin
                    g_id[g_n] = ev_id; g_val[g_n] = ev_val; g_slot[g_n] = now_slot;
                end
                g_n++;
            end
            if (idle) break;
            tick();
        end
        ev_ready = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 idle", idle, 1);
        chk("R1 ev_valid", ev_valid, 0);
        chk("R1 now_slot", now_slot, 0);
        chk("R1 flags", {sch_err, sch_ovf, osc_flag}, 0);
    endtask

    task automatic t_delay();
        int c;
        c = now_slot;
        sched(3, 1, 3);
        drain();
        chk("R2 count", g_n, 1);
        chk("R2 id", g_id[0], 3);
        chk("R2 val", g_val[0], 1);
        chk("R2 slot", g_slot[0], (c + 3) % NS);
        chk("R4 latency d=3", g_first, 3);
        c = now_slot;
        sched(9, 0, MAX_DLY);
        chk("R6 max delay no err", sch_err, 0);
        drain();
        chk("R4 wrap slot", g_slot[0], (c + MAX_DLY) % NS);
        chk("R4 latency d=max", g_first, MAX_DLY);
        chk("R2 id wrap", g_id[0], 9);
        chk("R2 val wrap", g_val[0], 0);
    endtask

    task automatic t_idle();
        int s;
        s = now_slot;
        repeat (5) tick();
        chk("R5 idle", idle, 1);
        chk("R5 pointer held", now_slot, s);
    endtask

    task automatic t_err();
        sched(4, 1, 0);
        chk("R6 err on zero", sch_err, 1);
        tick();
        chk("R6 err one cycle", sch_err, 0);
        chk("R6 nothing queued", idle, 1);
        sched(4, 1, MAX_DLY + 2);
        chk("R6 err on too large", sch_err, 1);
        tick();
        chk("R6 nothing queued 2", idle, 1);
    endtask

    task automatic t_redundant();
        sched(3, 1, 2);
        drain();
        sched(3, 1, 2);
        chk("R7 repeat dropped", idle, 1);
        chk("R7 no flag", {sch_err, sch_ovf}, 0);
        sched(3, 0, 2);
        chk("R7 change accepted", idle, 0);
        drain();
        chk("R7 one event", g_n, 1);
        chk("R7 value", g_val[0], 0);
        sched(4, 1, 1);
        chk("R6 rejected left value unknown", idle, 0);
        drain();
    endtask

    task automatic t_full();
        int c;
        do_reset();
        sched(15, 1, 1);
        tick(); tick();
        chk("R3 anchor slot", now_slot, 1);
        c = now_slot;
        for (int i = 0; i < DEPTH; i++) sched(i, 1, 2);
        chk("R8 no ovf at depth", sch_ovf, 0);
        sched(8, 1, 2);
        chk("R8 ovf pulse", sch_ovf, 1);
        tick();
        chk("R8 ovf one cycle", sch_ovf, 0);
        sched(8, 1, 3);
        chk("R8 lsv kept after drop", sch_ovf, 0);
        chk("R3 stall pointer", now_slot, c);
        chk("R3 stall head", {ev_valid, 4'(ev_id)}, {1'b1, 4'd15});
        drain();
        chk("R8 total events", g_n, DEPTH + 2);
        chk("R3 first", g_id[0], 15);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R3 order", g_id[i + 1], i);
            chk("R2 slot burst", g_slot[i + 1], (c + 2) % NS);
        end
        chk("R8 re-sched id", g_id[DEPTH + 1], 8);
        chk("R8 re-sched slot", g_slot[DEPTH + 1], (c + 3) % NS);
    endtask

    task automatic t_osc();
        do_reset();
        osc_limit = 8'd3;
        pi_pulse();
        for (int i = 0; i < 3; i++) sched(i, 1, 1);
        drain();
        chk("R9 three events", g_n, 3);
        chk("R9 at limit no flag", osc_flag, 0);
        pi_pulse();
        for (int i = 0; i < 3; i++) sched(i, 0, 2);
        drain();
        chk("R10 cleared count", osc_flag, 0);
        sched(3, 1, 1);
        drain();
        chk("R9 above limit flag", osc_flag, 1);
        pi_pulse();
        chk("R9 sticky", osc_flag, 1);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_delay();
        t_idle();
        t_err();
        t_redundant();
        t_full();
        t_osc();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule